// File: doc/BRIEF.md
# Predictor State Migration Engine

When a thread moves from a source core to an idle target core, this engine carries the source's branch predictor tables across so the target does not have to train its predictor from nothing. A migrate command starts a transfer. The engine waits for the target to finish its power-up initialization. It then streams predictor rows over a 128-bit inter-core bus, one row per beat. It uses only those cycles in which the source's predictor RAM port is free.

The source may take the bus back at any time for its architectural-state transfer. While it holds the bus, the copy halts. The copy then resumes with the rows still outstanding. One sent bit per row records what has been delivered. A row the source rewrites after its beat was accepted stays as delivered. A row rewritten before its beat carries the newer value.

A copy mode limits the transfer to the base table, the base table plus the first four tagged tables, or the whole RAM. Throughout the migration, a counter tallies executed branches. That tally decides how many high-order bits of the transferred global history get replaced with zeros, ones, or a pattern taken from the target's first program counter.

Top module: `pred_mig_engine`

## Requirements
- R1: A migrate command is taken only while idle; a command during a transfer has no effect. No bus beat is offered before `init_done_i` has been seen high in the initialization phase.
- R2: A beat is offered only in a cycle where `src_port_busy_i` and `arch_xfer_i` are both low. The beat carries the source row read in that same cycle, and `src_rd_en_o`/`src_rd_addr_o` name that row.
- R3: While `arch_xfer_i` is high, no beats are offered; afterwards copying resumes. Each selected row crosses exactly once per migration, always the lowest-numbered row not yet sent.
- R4: A row counts as sent in the cycle its beat is accepted (`bus_valid_o` and `bus_ready_i`). The target holds the source value of that acceptance cycle: a source write in that cycle or later is not carried, and a write in an earlier cycle is.
- R5: `copy_mode_i` = 0 selects rows 0..BASE_ROWS-1, 1 selects rows 0..PART_ROWS-1, 2 or 3 selects all ROWS rows. Target rows outside the selection are never written.
- R6: Every accepted beat produces a target write one cycle later with the same row address and data.
- R7: Branch pulses on `branch_i` are counted from the migrate command to the end of the table copy. The count saturates at GHR_W, and the final count k sets how many top history bits are replaced.
- R8: `fill_mode_i` = 0 passes the source history unchanged; 1 fills the top k bits with zeros; 2 with ones; 3 with bit i of the fill taken from `tgt_pc_i[i mod PC_W]`.
- R9: The history write (`tgt_ghr_we_o`, one cycle) comes in the cycle after the final target row write. `done_o` pulses in the following cycle, when the engine is idle again.
- R10: After reset, all strobe outputs (`src_rd_en_o`, `bus_valid_o`, `tgt_wr_en_o`, `tgt_ghr_we_o`, `done_o`) are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mig_start_i | input | 1 | Migrate command pulse |
| copy_mode_i | input | 2 | Table selection, sampled at start |
| fill_mode_i | input | 2 | History fill selection, sampled at start |
| init_done_i | input | 1 | Target initialization finished |
| arch_xfer_i | input | 1 | Source holds the bus for architectural-state transfer |
| src_port_busy_i | input | 1 | Source predictor RAM port in use by the core |
| src_rd_en_o | output | 1 | Source RAM read strobe |
| src_rd_addr_o | output | AW | Source RAM row address |
| src_rd_data_i | input | BUS_W | Source RAM row data, same cycle |
| bus_valid_o | output | 1 | Beat offered on the inter-core bus |
| bus_ready_i | input | 1 | Bus accepts the beat |
| bus_addr_o | output | AW | Row carried by the beat |
| bus_data_o | output | BUS_W | Row contents carried by the beat |
| tgt_wr_en_o | output | 1 | Target RAM write strobe |
| tgt_wr_addr_o | output | AW | Target RAM row address |
| tgt_wr_data_o | output | BUS_W | Target RAM row data |
| branch_i | input | 1 | One branch executed on the source |
| tgt_pc_i | input | PC_W | Program counter of the first target instruction |
| src_ghr_i | input | GHR_W | Source global history |
| tgt_ghr_we_o | output | 1 | Target history write strobe |
| tgt_ghr_o | output | GHR_W | Reconciled history value |
| done_o | output | 1 | Migration complete pulse |

## Verification
The bench sweeps every copy mode against every fill mode, with branch counts that run past saturation. It also moves the bus stalls, port-busy cycles and bus-takeover windows around the start of the copy. It rewrites source rows before, during and after their beats, including in the very cycle of acceptance. A design that marked rows sent at offer instead of acceptance, or that re-read a row after a pause, would put the wrong value in the target. A design that skipped or repeated rows across a takeover would show a wrong beat count or order. An off-by-one in the history mask would corrupt one bit right at the saturation boundary. A command taken mid-transfer would restart the copy and overshoot the expected beat count.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_COPY,
    ST_PAUSE,
    ST_HIST
  } pm_state_e;

  localparam logic [1:0] CM_BASE = 2'd0;
  localparam logic [1:0] CM_PART = 2'd1;

  localparam logic [1:0] FM_KEEP = 2'd0;
  localparam logic [1:0] FM_ZERO = 2'd1;
  localparam logic [1:0] FM_ONE  = 2'd2;
  localparam logic [1:0] FM_PC   = 2'd3;
endpackage

// File: rtl/pm_sent_tracker.sv
module pm_sent_tracker #(
  parameter int ROWS = 32,
  parameter int AW   = $clog2(ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          set_i,
  input  logic [AW-1:0] set_addr_i,
  input  logic [AW:0]   limit_i,
  output logic [AW-1:0] nxt_addr_o,
  output logic          left_o
);
  logic [ROWS-1:0] sent_q;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  sent_q[r] <= 1'b0;
      else if (clr_i)                               sent_q[r] <= 1'b0;
      else if (set_i && (set_addr_i == AW'(r)))     sent_q[r] <= 1'b1;
    end
  end

  // lowest selected row still outstanding
  always_comb begin
    left_o     = 1'b0;
    nxt_addr_o = '0;
    for (int r = ROWS - 1; r >= 0; r--) begin
      if (!sent_q[r] && ((AW+1)'(r) < limit_i)) begin
        left_o     = 1'b1;
        nxt_addr_o = AW'(r);
      end
    end
  end
endmodule

// File: rtl/pm_hist_merge.sv
module pm_hist_merge
  import pm_pkg::*;
#(
  parameter int GHR_W = 64,
  parameter int PC_W  = 32,
  parameter int CW    = $clog2(GHR_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             cnt_en_i,
  input  logic             branch_i,
  input  logic [1:0]       mode_i,
  input  logic [GHR_W-1:0] ghr_i,
  input  logic [PC_W-1:0]  pc_i,
  output logic [GHR_W-1:0] ghr_o
);
  logic [CW-1:0]    cnt_q;
  logic [GHR_W-1:0] mask;
  logic [GHR_W-1:0] fill;
  logic [GHR_W-1:0] pc_pat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          cnt_q <= '0;
    else if (clr_i)                                       cnt_q <= '0;
    else if (cnt_en_i && branch_i && (cnt_q != CW'(GHR_W))) cnt_q <= cnt_q + 1'b1;
  end

  for (genvar i = 0; i < GHR_W; i++) begin : g_pc
    assign pc_pat[i] = pc_i[i % PC_W];
  end

  always_comb begin
    for (int i = 0; i < GHR_W; i++) mask[i] = (int'(cnt_q) + i) >= GHR_W;
  end

  always_comb begin
    unique case (mode_i)
      FM_ZERO: fill = '0;
      FM_ONE:  fill = '1;
      FM_PC:   fill = pc_pat;
      default: fill = ghr_i;
    endcase
  end

  assign ghr_o = (ghr_i & ~mask) | (fill & mask);
endmodule

// File: rtl/pm_tgt_writer.sv
module pm_tgt_writer #(
  parameter int AW = 5,
  parameter int DW = 128
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o   <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      we_o <= acc_i;
      if (acc_i) begin
        addr_o <= addr_i;
        data_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/pred_mig_engine.sv
module pred_mig_engine
  import pm_pkg::*;
#(
  parameter int BUS_W     = 128,
  parameter int ROWS      = 32,
  parameter int BASE_ROWS = 8,
  parameter int PART_ROWS = 20,
  parameter int GHR_W     = 64,
  parameter int PC_W      = 32,
  localparam int AW       = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mig_start_i,
  input  logic [1:0]       copy_mode_i,
  input  logic [1:0]       fill_mode_i,
  input  logic             init_done_i,
  input  logic             arch_xfer_i,
  input  logic             src_port_busy_i,
  output logic             src_rd_en_o,
  output logic [AW-1:0]    src_rd_addr_o,
  input  logic [BUS_W-1:0] src_rd_data_i,
  output logic             bus_valid_o,
  input  logic             bus_ready_i,
  output logic [AW-1:0]    bus_addr_o,
  output logic [BUS_W-1:0] bus_data_o,
  output logic             tgt_wr_en_o,
  output logic [AW-1:0]    tgt_wr_addr_o,
  output logic [BUS_W-1:0] tgt_wr_data_o,
  input  logic             branch_i,
  input  logic [PC_W-1:0]  tgt_pc_i,
  input  logic [GHR_W-1:0] src_ghr_i,
  output logic             tgt_ghr_we_o,
  output logic [GHR_W-1:0] tgt_ghr_o,
  output logic             done_o
);
  localparam logic [AW:0] LIM_BASE = (AW+1)'(BASE_ROWS);
  localparam logic [AW:0] LIM_PART = (AW+1)'(PART_ROWS);
  localparam logic [AW:0] LIM_ALL  = (AW+1)'(ROWS);

  pm_state_e     st_q, st_d;
  logic [1:0]    cm_q, fm_q;
  logic [AW:0]   limit;
  logic          start_ok, accept, left, cnt_en, done_q;
  logic [AW-1:0] nxt_addr;

  assign start_ok = (st_q == ST_IDLE) && mig_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cm_q   <= CM_BASE;
      fm_q   <= FM_KEEP;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == ST_HIST);
      if (start_ok) begin
        cm_q <= copy_mode_i;
        fm_q <= fill_mode_i;
      end
    end
  end

  always_comb begin
    unique case (cm_q)
      CM_BASE: limit = LIM_BASE;
      CM_PART: limit = LIM_PART;
      default: limit = LIM_ALL;
    endcase
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (mig_start_i) st_d = ST_INIT;
      ST_INIT:  if (init_done_i) st_d = ST_COPY;
      ST_COPY: begin
        if (!left)            st_d = ST_HIST;
        else if (arch_xfer_i) st_d = ST_PAUSE;
      end
      ST_PAUSE: if (!arch_xfer_i) st_d = ST_COPY;
      ST_HIST:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  // bus use yields to the core's own port access and to the state transfer
  assign bus_valid_o   = (st_q == ST_COPY) && !arch_xfer_i && !src_port_busy_i && left;
  assign bus_addr_o    = nxt_addr;
  assign bus_data_o    = src_rd_data_i;
  assign src_rd_en_o   = bus_valid_o;
  assign src_rd_addr_o = nxt_addr;
  assign accept        = bus_valid_o && bus_ready_i;

  pm_sent_tracker #(.ROWS(ROWS), .AW(AW)) u_sent (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (start_ok),
    .set_i      (accept),
    .set_addr_i (nxt_addr),
    .limit_i    (limit),
    .nxt_addr_o (nxt_addr),
    .left_o     (left)
  );

  pm_tgt_writer #(.AW(AW), .DW(BUS_W)) u_wr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .acc_i  (accept),
    .addr_i (bus_addr_o),
    .data_i (bus_data_o),
    .we_o   (tgt_wr_en_o),
    .addr_o (tgt_wr_addr_o),
    .data_o (tgt_wr_data_o)
  );

  assign cnt_en = (st_q == ST_INIT) || (st_q == ST_COPY) || (st_q == ST_PAUSE);

  pm_hist_merge #(.GHR_W(GHR_W), .PC_W(PC_W)) u_hist (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (start_ok),
    .cnt_en_i (cnt_en),
    .branch_i (branch_i),
    .mode_i   (fm_q),
    .ghr_i    (src_ghr_i),
    .pc_i     (tgt_pc_i),
    .ghr_o    (tgt_ghr_o)
  );

  assign tgt_ghr_we_o = (st_q == ST_HIST);
  assign done_o       = done_q;
endmodule

// File: rtl/pm_engine_chk.sv
module pm_engine_chk
  import pm_pkg::*;
#(
  parameter int ROWS  = 32,
  parameter int AW    = 5,
  parameter int BUS_W = 128
) (
  input logic             clk_i,
  input logic             rst_ni,
  input pm_state_e        st_q,
  input logic             mig_start_i,
  input logic             init_done_i,
  input logic             arch_xfer_i,
  input logic             src_port_busy_i,
  input logic             bus_valid_o,
  input logic             bus_ready_i,
  input logic [AW-1:0]    bus_addr_o,
  input logic [BUS_W-1:0] bus_data_o,
  input logic [BUS_W-1:0] src_rd_data_i,
  input logic             tgt_wr_en_o,
  input logic [AW-1:0]    tgt_wr_addr_o,
  input logic             tgt_ghr_we_o,
  input logic             done_o
);
  logic [ROWS-1:0] seen_q;
  logic            init_seen_q;
  logic            begin_mig;

  assign begin_mig = (st_q == ST_IDLE) && mig_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q      <= '0;
      init_seen_q <= 1'b0;
    end else begin
      if (begin_mig) begin
        seen_q      <= '0;
        init_seen_q <= 1'b0;
      end else begin
        if (st_q == ST_INIT && init_done_i) init_seen_q <= 1'b1;
        if (bus_valid_o && bus_ready_i)     seen_q[bus_addr_o] <= 1'b1;
      end
    end
  end

  p_beat_after_init_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> init_seen_q);

  p_port_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> (!src_port_busy_i && !arch_xfer_i));

  p_beat_data_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> (bus_data_o == src_rd_data_i));

  p_row_once_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> !seen_q[bus_addr_o]);

  p_tgt_follow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && bus_ready_i) |=> (tgt_wr_en_o && tgt_wr_addr_o == $past(bus_addr_o)));

  p_hist_then_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_ghr_we_o |=> (!tgt_ghr_we_o && done_o));

  p_hist_apart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_ghr_we_o |-> !tgt_wr_en_o);
endmodule

bind pred_mig_engine pm_engine_chk #(.ROWS(ROWS), .AW(AW), .BUS_W(BUS_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .st_q            (st_q),
  .mig_start_i     (mig_start_i),
  .init_done_i     (init_done_i),
  .arch_xfer_i     (arch_xfer_i),
  .src_port_busy_i (src_port_busy_i),
  .bus_valid_o     (bus_valid_o),
  .bus_ready_i     (bus_ready_i),
  .bus_addr_o      (bus_addr_o),
  .bus_data_o      (bus_data_o),
  .src_rd_data_i   (src_rd_data_i),
  .tgt_wr_en_o     (tgt_wr_en_o),
  .tgt_wr_addr_o   (tgt_wr_addr_o),
  .tgt_ghr_we_o    (tgt_ghr_we_o),
  .done_o          (done_o)
);

// File: tb/pred_mig_engine_bench.sv
module pred_mig_engine_bench;
  localparam int ROWS = 16, BASE = 4, PART = 10, DW = 32, GW = 16, PW = 8, AW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mig_start_i, init_done_i, arch_xfer_i, src_port_busy_i;
  logic [1:0]    copy_mode_i, fill_mode_i;
  logic          src_rd_en_o, bus_valid_o, bus_ready_i, tgt_wr_en_o, branch_i;
  logic          tgt_ghr_we_o, done_o;
  logic [AW-1:0] src_rd_addr_o, bus_addr_o, tgt_wr_addr_o;
  logic [DW-1:0] src_rd_data_i, bus_data_o, tgt_wr_data_o;
  logic [PW-1:0] tgt_pc_i;
  logic [GW-1:0] src_ghr_i, tgt_ghr_o;

  logic [DW-1:0] src_mem [ROWS];
  logic [DW-1:0] tgt_mem [ROWS];
  logic [DW-1:0] exp_tgt [ROWS];
  logic          sent_seen [ROWS];

  int tests = 0, fails = 0, cyc_total = 0;

  always #5 clk = ~clk;

  assign src_rd_data_i = src_mem[src_rd_addr_o];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) tgt_mem[r] <= 32'hdead_0000 | DW'(r);
    end else if (tgt_wr_en_o) begin
      tgt_mem[tgt_wr_addr_o] <= tgt_wr_data_o;
    end
  end

  pred_mig_engine #(
    .BUS_W(DW), .ROWS(ROWS), .BASE_ROWS(BASE), .PART_ROWS(PART), .GHR_W(GW), .PC_W(PW)
  ) u_pred_mig_engine (
    .clk_i(clk), .rst_ni(rst_n), .mig_start_i(mig_start_i), .copy_mode_i(copy_mode_i),
    .fill_mode_i(fill_mode_i), .init_done_i(init_done_i), .arch_xfer_i(arch_xfer_i),
    .src_port_busy_i(src_port_busy_i), .src_rd_en_o(src_rd_en_o), .src_rd_addr_o(src_rd_addr_o),
    .src_rd_data_i(src_rd_data_i), .bus_valid_o(bus_valid_o), .bus_ready_i(bus_ready_i),
    .bus_addr_o(bus_addr_o), .bus_data_o(bus_data_o), .tgt_wr_en_o(tgt_wr_en_o),
    .tgt_wr_addr_o(tgt_wr_addr_o), .tgt_wr_data_o(tgt_wr_data_o), .branch_i(branch_i),
    .tgt_pc_i(tgt_pc_i), .src_ghr_i(src_ghr_i), .tgt_ghr_we_o(tgt_ghr_we_o),
    .tgt_ghr_o(tgt_ghr_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc_total);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic run_mig(input int run);
    int cm = run >> 2;
    int fm = run & 3;
    int nb = (run * 7) % 20;
    int lim = (cm == 0) ? BASE : ((cm == 1) ? PART : ROWS);
    int k = (nb > GW) ? GW : nb;
    int beats = 0, lowest;
    bit done = 0, prev_acc = 0, prev_tw = 0, prev_ghr = 0, acc;
    logic [AW-1:0] pa;
    logic [DW-1:0] pd;
    logic [GW-1:0] exp_ghr;
    bit wr_now, sch_done = 0, sch_sent = 0, col_done = 0;
    int wr_a, sch_a = run % lim;
    logic [DW-1:0] wr_d, sch_old = '0, sch_new = '0, col_old = '0;

    for (int r = 0; r < ROWS; r++) begin
      src_mem[r]   = {8'(run), 8'(r), 16'ha5c3};
      sent_seen[r] = 1'b0;
    end
    src_ghr_i = 16'h9c35 ^ 16'(run * 29);
    tgt_pc_i  = 8'(8'h6b + run);
    for (int i = 0; i < GW; i++) begin
      if (i < GW - k) exp_ghr[i] = src_ghr_i[i];
      else case (fm)
        1: exp_ghr[i] = 1'b0;
        2: exp_ghr[i] = 1'b1;
        3: exp_ghr[i] = tgt_pc_i[i % PW];
        default: exp_ghr[i] = src_ghr_i[i];
      endcase
    end

    @(negedge clk);
    copy_mode_i = 2'(cm);
    fill_mode_i = 2'(fm);
    mig_start_i = 1'b1;
    @(posedge clk);

    for (int cyc = 0; cyc < 400 && !done; cyc++) begin
      @(negedge clk);
      mig_start_i     = (cyc == 22);  // must be ignored mid-transfer (R1)
      init_done_i     = (cyc >= 20);
      src_port_busy_i = run[0] && (cyc % 5 == 3);
      bus_ready_i     = !(run[1] && (cyc % 4 == 1));
      arch_xfer_i     = ((run % 3 == 1) && cyc >= 21 && cyc < 26) ||
                        ((run % 3 == 2) && cyc >= 24 && cyc < 31);
      branch_i        = (cyc >= 1 && cyc <= nb);
      #1;
      if (bus_valid_o) begin
        lowest = lim;
        for (int r = lim - 1; r >= 0; r--) if (!sent_seen[r]) lowest = r;
        chk(cyc > 20, "R1 beat before init", 64'(cyc), 64'd21);
        chk(!src_port_busy_i && !arch_xfer_i, "R2 beat while port or bus taken",
            {src_port_busy_i, arch_xfer_i}, 64'd0);
        chk(src_rd_en_o && src_rd_addr_o == bus_addr_o, "R2 read row", 64'(src_rd_addr_o), 64'(bus_addr_o));
        chk(bus_data_o == src_mem[bus_addr_o], "R2 beat data", 64'(bus_data_o), 64'(src_mem[bus_addr_o]));
        chk(int'(bus_addr_o) == lowest, "R3 row order", 64'(bus_addr_o), 64'(lowest));
        chk(int'(bus_addr_o) < lim, "R5 row outside selection", 64'(bus_addr_o), 64'(lim));
      end
      acc = bus_valid_o && bus_ready_i;
      if (prev_acc)
        chk(tgt_wr_en_o && tgt_wr_addr_o == pa && tgt_wr_data_o == pd, "R6 target write",
            {tgt_wr_en_o, 28'd0, tgt_wr_addr_o, tgt_wr_data_o}, {1'b1, 28'd0, pa, pd});
      else
        chk(!tgt_wr_en_o, "R6 spurious target write", 64'(tgt_wr_en_o), 64'd0);
      if (tgt_ghr_we_o) begin
        chk(tgt_ghr_o == exp_ghr, "R8 R7 history value", 64'(tgt_ghr_o), 64'(exp_ghr));
        chk(prev_tw, "R9 history not right after last row", 64'(prev_tw), 64'd1);
      end
      if (done_o) begin
        chk(prev_ghr, "R9 done not after history", 64'(prev_ghr), 64'd1);
        done = 1;
      end
      if (acc) begin
        exp_tgt[bus_addr_o]   = src_mem[bus_addr_o];
        sent_seen[bus_addr_o] = 1'b1;
        beats++;
      end
      wr_now = 0;
      if (cyc == 30) begin
        wr_now = 1; wr_a = sch_a; wr_d = ~src_mem[sch_a];
        sch_done = 1; sch_sent = sent_seen[sch_a]; sch_old = src_mem[sch_a]; sch_new = wr_d;
      end else if (run[0] && acc && bus_addr_o == 4'd2 && !col_done) begin
        wr_now = 1; wr_a = 2; wr_d = src_mem[2] ^ 32'h0f0f_0f0f;
        col_done = 1; col_old = src_mem[2];
      end
      prev_acc = acc; pa = bus_addr_o; pd = bus_data_o;
      prev_tw  = tgt_wr_en_o; prev_ghr = tgt_ghr_we_o;
      @(posedge clk);
      #1;
      if (wr_now) src_mem[wr_a] = wr_d;
    end

    chk(done, "R9 no done pulse", 64'(done), 64'd1);
    chk(beats == lim, "R5 R1 beat count", 64'(beats), 64'(lim));
    for (int r = 0; r < ROWS; r++)
      chk(tgt_mem[r] == exp_tgt[r], "R5 R6 target row", 64'(tgt_mem[r]), 64'(exp_tgt[r]));
    if (sch_done && !(col_done && sch_a == 2))
      chk(tgt_mem[sch_a] == (sch_sent ? sch_old : sch_new), "R4 write vs sent",
          64'(tgt_mem[sch_a]), 64'(sch_sent ? sch_old : sch_new));
    if (col_done && !(sch_done && sch_a == 2))
      chk(tgt_mem[2] == col_old, "R4 same-cycle write", 64'(tgt_mem[2]), 64'(col_old));
  endtask

  initial begin
    rst_n = 1'b0;
    mig_start_i = 0; init_done_i = 0; arch_xfer_i = 0; src_port_busy_i = 0;
    bus_ready_i = 0; branch_i = 0; copy_mode_i = 0; fill_mode_i = 0;
    tgt_pc_i = 0; src_ghr_i = 0;
    for (int r = 0; r < ROWS; r++) begin
      src_mem[r] = '0;
      exp_tgt[r] = 32'hdead_0000 | DW'(r);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({src_rd_en_o, bus_valid_o, tgt_wr_en_o, tgt_ghr_we_o, done_o} == 5'b0,
        "R10 reset strobes", 64'({src_rd_en_o, bus_valid_o, tgt_wr_en_o, tgt_ghr_we_o, done_o}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_valid_o && !done_o, "R10 idle after reset", 64'({bus_valid_o, done_o}), 64'd0);
    for (int run = 0; run < 16; run++) run_mig(run);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule